// File: doc/BRIEF.md
# Guest-Stage Translation Control Register

This block holds the 64-bit control register that sets how a hypervisor-capable core translates guest physical addresses into host physical addresses. Software reaches it through a simple write port (data plus enable) and a read-data output. The page walker uses the decoded outputs: the translation scheme, the virtual-machine identifier and the root page-table page number. An `active` qualifier tells the walker whether the register applies to the current effective privilege.

Every field is write-any-read-legal. A write is accepted only if it names a scheme the build supports. A write that selects Bare clears every other field. In the paged schemes the root page number is held to a 16 KiB boundary. Only a configured number of low identifier bits can hold a value. Software can learn how wide the identifier is by writing all ones and reading the register back.

Top module: `gstage_atp_reg`

## Requirements
- R1: After reset the register reads as all zeros, which selects Bare (mode code 0).
- R2: Bits [63:60] hold the mode: 0 is Bare, 8 is the 39-bit-plus-2 scheme, 9 the 48-bit-plus-2 scheme and 10 the 57-bit-plus-2 scheme. The parameter SUPPORT_MASK (bit 0 for 8, bit 1 for 9, bit 2 for 10; default 3'b011) selects which paged schemes are supported. A write with `wrEn` high and a supported mode takes effect on the next clock edge.
- R3: A write whose mode code is reserved (1 to 7, 11 to 15) or unsupported leaves the whole register unchanged.
- R4: An accepted write of mode 0 stores zero in every other bit, whatever the write data holds.
- R5: In paged modes the root page number sits in bits [43:0]. Bits [43:2] take the written value and bits [1:0] always read as zero.
- R6: The identifier sits in bits [57:44]. Only its lowest VMID_LEN bits (parameter, 0 to 14, default 7) are writable. Its higher bits always read as zero.
- R7: Bits [59:58] always read as zero.
- R8: `modeOut`, `vmidOut` and `rootPpn` always equal the corresponding fields of `rdData`.
- R9: `active` is 1 exactly when `virt` is 1 and `priv` is 2'b00 (user) or 2'b01 (supervisor).
- R10: While `wrEn` is low the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Write data |
| virt | input | 1 | Effective privilege is virtualized |
| priv | input | 2 | Effective privilege level (00 user, 01 supervisor, 11 machine) |
| rdData | output | 64 | Legalized register value |
| modeOut | output | 4 | Decoded mode code |
| vmidOut | output | 14 | Decoded identifier |
| rootPpn | output | 44 | Root page-table page number |
| active | output | 1 | Register applies to the current privilege |

## Verification
Every write changes the register on the next edge, and the whole state is visible on `rdData`. A wrong internal state therefore shows up one cycle after the write that caused it: a stale mode, a nonzero low page bit, or a stray identifier bit above the configured width. The sweep covers all sixteen mode codes with several data patterns and reads back after each write. A corrupted update that was wrongly accepted or wrongly dropped shows as a mismatch on the next read.

// File: rtl/gstage_atp_pkg.sv
package gstage_atp_pkg;
  localparam int REG_W      = 64;
  localparam int MODE_W     = 4;
  localparam int VMID_MAX   = 14;
  localparam int PPN_W      = 44;
  localparam int VMID_LSB   = 44;
  localparam int MODE_LSB   = 60;

  localparam logic [MODE_W-1:0] MODE_BARE = 4'd0;
  localparam logic [MODE_W-1:0] MODE_P39  = 4'd8;
  localparam logic [MODE_W-1:0] MODE_P48  = 4'd9;
  localparam logic [MODE_W-1:0] MODE_P57  = 4'd10;

  typedef struct packed {
    logic load;      // accept the write
    logic clearRest; // write selects Bare: zero other fields
  } atpStrobe_t;
endpackage

// File: rtl/gstage_atp_ctrl.sv
module gstage_atp_ctrl
  import gstage_atp_pkg::*;
#(
  parameter logic [2:0] SUPPORT_MASK = 3'b011
) (
  input  logic              wrEn,
  input  logic [MODE_W-1:0] wrMode,
  input  logic              virt,
  input  logic [1:0]        priv,
  output atpStrobe_t        strobe,
  output logic              active
);
  logic [2:0] pagedHit;
  logic       modeOk;

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_paged
      localparam logic [MODE_W-1:0] CODE = MODE_P39 + MODE_W'(g);
      assign pagedHit[g] = SUPPORT_MASK[g] && (wrMode == CODE);
    end
  endgenerate

  always_comb begin
    modeOk           = (wrMode == MODE_BARE) || (|pagedHit);
    strobe.load      = wrEn && modeOk;
    strobe.clearRest = (wrMode == MODE_BARE);
    active           = virt && ((priv == 2'b00) || (priv == 2'b01));
  end
endmodule

// File: rtl/gstage_atp_dpath.sv
module gstage_atp_dpath
  import gstage_atp_pkg::*;
#(
  parameter int VMID_LEN = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  atpStrobe_t          strobe,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  output logic [MODE_W-1:0]   modeOut,
  output logic [VMID_MAX-1:0] vmidOut,
  output logic [PPN_W-1:0]    rootPpn
);
  localparam int PPN_HI_W = PPN_W - 2;

  logic [MODE_W-1:0]   modeQ;
  logic [PPN_HI_W-1:0] ppnHiQ;
  logic [VMID_MAX-1:0] vmidWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_BARE;
      ppnHiQ <= '0;
    end else if (strobe.load) begin
      modeQ  <= wrData[MODE_LSB +: MODE_W];
      ppnHiQ <= strobe.clearRest ? '0 : wrData[2 +: PPN_HI_W];
    end
  end

  generate
    if (VMID_LEN > 0) begin : g_vmid
      logic [VMID_LEN-1:0] vmidQ;
      always_ff @(posedge clk) begin
        if (!rstN)
          vmidQ <= '0;
        else if (strobe.load)
          vmidQ <= strobe.clearRest ? '0 : wrData[VMID_LSB +: VMID_LEN];
      end
      if (VMID_LEN < VMID_MAX) begin : g_pad
        assign vmidWide = {{(VMID_MAX-VMID_LEN){1'b0}}, vmidQ};
      end else begin : g_full
        assign vmidWide = vmidQ;
      end
    end else begin : g_novmid
      assign vmidWide = '0;
    end
  endgenerate

  always_comb begin
    modeOut = modeQ;
    vmidOut = vmidWide;
    rootPpn = {ppnHiQ, 2'b00};
    rdData  = {modeQ, 2'b00, vmidWide, ppnHiQ, 2'b00};
  end
endmodule

// File: rtl/gstage_atp_reg.sv
module gstage_atp_reg
  import gstage_atp_pkg::*;
#(
  parameter int         VMID_LEN     = 7,
  parameter logic [2:0] SUPPORT_MASK = 3'b011
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [63:0]  wrData,
  input  logic         virt,
  input  logic [1:0]   priv,
  output logic [63:0]  rdData,
  output logic [3:0]   modeOut,
  output logic [13:0]  vmidOut,
  output logic [43:0]  rootPpn,
  output logic         active
);
  atpStrobe_t strobe;

  gstage_atp_ctrl #(.SUPPORT_MASK(SUPPORT_MASK)) u_ctrl (
    .wrEn   (wrEn),
    .wrMode (wrData[MODE_LSB +: MODE_W]),
    .virt   (virt),
    .priv   (priv),
    .strobe (strobe),
    .active (active)
  );

  gstage_atp_dpath #(.VMID_LEN(VMID_LEN)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .rdData  (rdData),
    .modeOut (modeOut),
    .vmidOut (vmidOut),
    .rootPpn (rootPpn)
  );
endmodule

// File: rtl/gstage_atp_chk.sv
module gstage_atp_chk #(
  parameter int         VMID_LEN     = 7,
  parameter logic [2:0] SUPPORT_MASK = 3'b011
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [63:0] wrData,
  input logic        virt,
  input logic [1:0]  priv,
  input logic [63:0] rdData,
  input logic [3:0]  modeOut,
  input logic [13:0] vmidOut,
  input logic [43:0] rootPpn,
  input logic        active
);
  logic [3:0] wm;
  logic       wmOk;
  assign wm   = wrData[63:60];
  assign wmOk = (wm == 4'd0) || (wm == 4'd8 && SUPPORT_MASK[0]) ||
                (wm == 4'd9 && SUPPORT_MASK[1]) || (wm == 4'd10 && SUPPORT_MASK[2]);

  // R2: stored mode is always one the build accepts
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 4'd0) || (modeOut == 4'd8 && SUPPORT_MASK[0]) ||
    (modeOut == 4'd9 && SUPPORT_MASK[1]) || (modeOut == 4'd10 && SUPPORT_MASK[2]));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wmOk) |=> (rdData[63:60] == $past(wm)));

  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wmOk) |=> $stable(rdData));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  a_r4_bare_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[63:60] == 4'd0) |-> (rdData[59:0] == 60'd0));

  a_r5_ppn_align: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1:0] == 2'b00);

  a_r7_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[59:58] == 2'b00);

  a_r8_fields: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == rdData[63:60]) && (vmidOut == rdData[57:44]) && (rootPpn == rdData[43:0]));

  a_r9_active_virt: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (virt && !priv[1]));

  generate
    if (VMID_LEN < 14) begin : g_vmid_hi
      a_r6_vmid_upper: assert property (@(posedge clk) disable iff (!rstN)
        (vmidOut >> VMID_LEN) == 14'd0);
    end
  endgenerate
endmodule

bind gstage_atp_reg gstage_atp_chk #(.VMID_LEN(VMID_LEN), .SUPPORT_MASK(SUPPORT_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .virt(virt), .priv(priv),
  .rdData(rdData), .modeOut(modeOut), .vmidOut(vmidOut), .rootPpn(rootPpn), .active(active)
);

// File: tb/tb_gstage_atp_reg.sv
module tb_gstage_atp_reg;
  localparam int         VLEN = 7;
  localparam logic [2:0] SUP  = 3'b011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        virt = 1'b0;
  logic [1:0]  priv = 2'b00;
  logic [63:0] rdData;
  logic [3:0]  modeOut;
  logic [13:0] vmidOut;
  logic [43:0] rootPpn;
  logic        active;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  gstage_atp_reg #(.VMID_LEN(VLEN), .SUPPORT_MASK(SUP)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .virt(virt), .priv(priv),
    .rdData(rdData), .modeOut(modeOut), .vmidOut(vmidOut), .rootPpn(rootPpn), .active(active)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic accepted(input logic [3:0] m);
    return (m == 4'd0) || (m == 4'd8 && SUP[0]) || (m == 4'd9 && SUP[1]) || (m == 4'd10 && SUP[2]);
  endfunction

  function automatic logic [63:0] nextVal(input logic [63:0] cur, input logic [63:0] d);
    logic [63:0] vmidMask;
    logic [3:0]  m;
    m = d[63:60];
    if (!accepted(m)) return cur;
    if (m == 4'd0) return 64'd0;
    vmidMask = ((64'd1 << VLEN) - 64'd1) << 44;
    return (d & (64'hF << 60)) | (d & vmidMask) | (d & 64'h0000_0FFF_FFFF_FFFC);
  endfunction

  task automatic writeAndCheck(input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model = nextVal(model, d);
    if (!accepted(d[63:60])) chk("R3 reject keeps value", rdData, model);
    else if (d[63:60] == 4'd0) chk("R4 bare clears", rdData, model);
    else chk("R2 accepted write", rdData, model);
    chk("R5 ppn low bits", {62'd0, rdData[1:0]}, 64'd0);
    chk("R6 vmid width", {50'd0, vmidOut}, (model >> 44) & 64'h3FFF);
    chk("R7 gap bits", {62'd0, rdData[59:58]}, 64'd0);
    chk("R8 decoded", {16'd0, modeOut, vmidOut, rootPpn}, {16'd0, model[63:60], model[57:44], model[43:0]});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rdData, 64'd0);

    // sweep every mode code with several patterns, preceded by a paged load
    for (int m = 0; m < 16; m++) begin
      writeAndCheck(64'h9ABC_DEF0_1234_5677);
      writeAndCheck({4'(m), 60'hFFF_FFFF_FFFF_FFFF});
      writeAndCheck({4'(m), 60'h555_5555_5555_5556});
      writeAndCheck({4'(m), 60'h0AA_AAAA_AAAA_AAA9});
    end

    // width discovery: all ones in a paged mode
    writeAndCheck({4'd8, 60'hFFF_FFFF_FFFF_FFFF});
    chk("R6 discovered vmid", {50'd0, vmidOut}, (64'd1 << VLEN) - 64'd1);
    chk("R5 ppn all ones", {20'd0, rootPpn}, 64'h0000_0FFF_FFFF_FFFC);

    // R10: data present but strobe low
    @(negedge clk);
    wrData = 64'h9000_0000_0000_1234;
    repeat (2) @(negedge clk);
    chk("R10 idle hold", rdData, model);

    // R9: all virt/priv combinations
    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        virt = v[0]; priv = 2'(p);
        #1;
        chk("R9 active", {63'd0, active}, {63'd0, (v == 1) && (p < 2)});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule